// File: doc/BRIEF.md
# Raster display task-wakeup controller

This block decides when the three display microtasks of a raster display controller get wakeup requests. The three tasks are a once-per-field vertical task, a horizontal task and a word-fetch task. The block also raises a cursor-task wakeup at the end of every horizontal retrace. It takes the timing flags of the current bit time as inputs and finds their edges against a registered copy from the previous bit time. From those edges, from the block requests issued by the tasks and from the fill state of a 16-word pixel FIFO, it produces registered wakeup lines.

The block also owns the FIFO read and write pointers and clears them at the start of each horizontal retrace. At that same moment it applies the display mode bits from the most recent mode write: an inverse-video XOR mask and half-clock operation. The falling edge of horizontal blanking starts an unload phase. That phase reports its word period, which is 32 bit times in half-clock mode and 16 otherwise, and it counts the words drained from the FIFO.

All outputs are registered. Each reacts in the clock cycle after the input condition is sampled. One clock is one bit time.

Top module: `dsp_wake_ctrl`

## Requirements
- R1: A rising edge of `vsync_i` while `vblank_i` is high sets `wake_dvt_o` in the next cycle. A rising edge of `vsync_i` while `vblank_i` is low has no effect. `blk_dvt_i` clears `wake_dvt_o` in the next cycle, unless a new rising edge arrives in the same cycle.
- R2: A falling edge of `vblank_i` sets `wake_dht_o` in the next cycle and clears the horizontal-task block flip-flop.
- R3: `blk_dht_i` sets the horizontal-task block flip-flop and clears `wake_dht_o` in the next cycle. A rising edge of `hsync_i` sets `wake_dht_o` only while that flip-flop is clear.
- R4: `wake_dwt_o` is 1 in the cycle after a cycle that meets all of these conditions: the word-task block flip-flop is clear and not being set, the horizontal-task block flip-flop is clear and not being set, and the FIFO is not full. In any other case it is 0. `blk_dwt_i` sets the word-task block flip-flop.
- R5: While `scanend_i` is high, `wake_dwt_o` is 0 in the following cycle.
- R6: `fifo_full_o` is 1 when 16 more words have been pushed than popped, and `fifo_empty_o` is 1 when the counts are equal. A push while full is ignored, and a pop while empty is ignored.
- R7: A rising edge of `hsync_i` produces a one-cycle `fifo_clr_o` pulse. It also empties the FIFO, clears the word-task block flip-flop and drops `unload_active_o`.
- R8: `mode_wr_i` stores the pending mode bits only. At the next rising edge of `hsync_i`, `pix_mask_o` becomes 0xFFFF if the stored invert bit is 1 and 0x0000 if it is 0, and `half_clk_o` takes the stored speed bit.
- R9: A falling edge of `hblank_i` produces a one-cycle `unload_start_o` pulse. It sets `unload_active_o`, resets `unload_word_o` to 0, and loads `unload_period_o` with 32 if `half_clk_o` is 1 or 16 if it is 0.
- R10: A falling edge of `hsync_i` sets `wake_curt_o` in the next cycle. `blk_curt_i` clears it.
- R11: After reset, all wakeups and pulses are 0, the FIFO is empty, `pix_mask_o` is 0, `half_clk_o` is 0 and `unload_period_o` is 16.
- R12: While `unload_active_o` is 1, each accepted pop increments `unload_word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_i | input | 1 | Vertical blanking flag |
| vsync_i | input | 1 | Vertical sync flag (inside blanking) |
| hblank_i | input | 1 | Horizontal blanking flag |
| hsync_i | input | 1 | Horizontal sync flag |
| scanend_i | input | 1 | End of the visible scan line |
| mode_wr_i | input | 1 | Store new pending mode bits |
| mode_invert_i | input | 1 | Pending inverse-video bit |
| mode_speedy_i | input | 1 | Pending half-clock bit |
| fifo_push_i | input | 1 | A word is written into the FIFO |
| fifo_pop_i | input | 1 | A word is read from the FIFO |
| blk_dvt_i | input | 1 | Vertical task block request |
| blk_dht_i | input | 1 | Horizontal task block request |
| blk_dwt_i | input | 1 | Word task block request |
| blk_curt_i | input | 1 | Cursor task block request |
| wake_dvt_o | output | 1 | Vertical task wakeup |
| wake_dht_o | output | 1 | Horizontal task wakeup |
| wake_dwt_o | output | 1 | Word task wakeup |
| wake_curt_o | output | 1 | Cursor task wakeup |
| fifo_clr_o | output | 1 | FIFO pointer clear pulse |
| fifo_full_o | output | 1 | FIFO holds 16 words |
| fifo_empty_o | output | 1 | FIFO holds no words |
| pix_mask_o | output | 16 | Active inverse-video XOR mask |
| half_clk_o | output | 1 | Active half-clock mode |
| unload_start_o | output | 1 | Start of line unload pulse |
| unload_period_o | output | 6 | Bit times per unloaded word |
| unload_active_o | output | 1 | Unload phase in progress |
| unload_word_o | output | 5 | Words drained in this unload phase |

## Verification
The condition that is hardest to reach is the word-task wakeup coming back. It needs a block flip-flop set and later released, by an edge of a different timing flag, while a full FIFO must also be drained. The bench first fills the FIFO with one extra push. It then sets each block in turn and releases it with the matching sync or blanking edge, sampling the wakeup one cycle and two cycles after the release. A table of timing-flag steps walks through two fields. Its entries put block requests on the same cycle as wake-raising edges, so the priority between the two can be observed.

// File: rtl/dsp_wake_pkg.sv
package dsp_wake_pkg;

    // timing flags that are edge-detected
    typedef struct packed {
        logic vblank;
        logic vsync;
        logic hblank;
        logic hsync;
    } tflags_t;

    // events derived from one bit time to the next
    typedef struct packed {
        logic field_start;    // vblank falling
        logic vert_pulse;     // vsync rising inside vblank
        logic line_unload;    // hblank falling
        logic retrace_begin;  // hsync rising
        logic retrace_end;    // hsync falling
    } tev_t;

    typedef struct packed {
        logic invert;
        logic speedy;
    } mode_t;

    function automatic tev_t find_events(tflags_t now, tflags_t was);
        tev_t e;
        e.field_start   = was.vblank & ~now.vblank;
        e.vert_pulse    = now.vsync & ~was.vsync & now.vblank;
        e.line_unload   = was.hblank & ~now.hblank;
        e.retrace_begin = now.hsync & ~was.hsync;
        e.retrace_end   = was.hsync & ~now.hsync;
        return e;
    endfunction

    function automatic int unload_bits(logic half, int base);
        return half ? 2 * base : base;
    endfunction

endpackage

// File: rtl/dsp_edge_det.sv
module dsp_edge_det
    import dsp_wake_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tflags_t flags_i,
    output tev_t    ev_o
);
    tflags_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= flags_i;
    end

    assign ev_o = find_events(flags_i, prev_q);

    // R7/R10: the start and end of retrace never coincide
    a_r7_retrace_edges_excl: assert property (@(posedge clk) disable iff (rst)
        !(ev_o.retrace_begin && ev_o.retrace_end));
endmodule

// File: rtl/dsp_fifo_ptrs.sv
module dsp_fifo_ptrs #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic push_i,
    input  logic pop_i,
    output logic full_o,
    output logic empty_o,
    output logic pop_ok_o
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;

    logic [PW-1:0] wr_q, rd_q;
    logic          push_ok;

    assign full_o   = (wr_q[IW] != rd_q[IW]) && (wr_q[IW-1:0] == rd_q[IW-1:0]);
    assign empty_o  = (wr_q == rd_q);
    assign push_ok  = push_i && !full_o;
    assign pop_ok_o = pop_i && !empty_o && !clr_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push_ok)  wr_q <= wr_q + PW'(1);
            if (pop_ok_o) rd_q <= rd_q + PW'(1);
        end
    end

    a_r6_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> empty_o);
    a_r6_push_ignored_when_full: assert property (@(posedge clk) disable iff (rst)
        full_o && !pop_i && !clr_i |=> full_o);
endmodule

// File: rtl/dsp_task_wake.sv
module dsp_task_wake
    import dsp_wake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  tev_t ev_i,
    input  logic scanend_i,
    input  logic fifo_full_i,
    input  logic blk_dvt_i,
    input  logic blk_dht_i,
    input  logic blk_dwt_i,
    input  logic blk_curt_i,
    output logic wake_dvt_o,
    output logic wake_dht_o,
    output logic wake_dwt_o,
    output logic wake_curt_o
);
    logic dvt_q, dht_q, dwt_q, curt_q;
    logic dht_blk_q, dwt_blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dvt_q     <= 1'b0;
            dht_q     <= 1'b0;
            dwt_q     <= 1'b0;
            curt_q    <= 1'b0;
            dht_blk_q <= 1'b0;
            dwt_blk_q <= 1'b0;
        end else begin
            // vertical task: once per field
            if (ev_i.vert_pulse)  dvt_q <= 1'b1;
            else if (blk_dvt_i)   dvt_q <= 1'b0;

            // horizontal task
            if (ev_i.field_start)                 dht_q <= 1'b1;
            else if (blk_dht_i)                   dht_q <= 1'b0;
            else if (ev_i.retrace_begin && !dht_blk_q) dht_q <= 1'b1;

            if (ev_i.field_start) dht_blk_q <= 1'b0;
            else if (blk_dht_i)   dht_blk_q <= 1'b1;

            // word task block flip-flop
            if (ev_i.retrace_begin) dwt_blk_q <= 1'b0;
            else if (blk_dwt_i)     dwt_blk_q <= 1'b1;

            // word task wakeup follows the FIFO and block state
            dwt_q <= !scanend_i && !dwt_blk_q && !blk_dwt_i &&
                     !dht_blk_q && !blk_dht_i && !fifo_full_i;

            // cursor task
            if (ev_i.retrace_end)  curt_q <= 1'b1;
            else if (blk_curt_i)   curt_q <= 1'b0;
        end
    end

    assign wake_dvt_o  = dvt_q;
    assign wake_dht_o  = dht_q;
    assign wake_dwt_o  = dwt_q;
    assign wake_curt_o = curt_q;

    a_r1_vert_wake: assert property (@(posedge clk) disable iff (rst)
        ev_i.vert_pulse |=> wake_dvt_o);
    a_r2_field_wake: assert property (@(posedge clk) disable iff (rst)
        ev_i.field_start |=> wake_dht_o);
    a_r4_full_no_wake: assert property (@(posedge clk) disable iff (rst)
        fifo_full_i |=> !wake_dwt_o);
    a_r5_scanend_no_wake: assert property (@(posedge clk) disable iff (rst)
        scanend_i |=> !wake_dwt_o);
    a_r10_cursor_wake: assert property (@(posedge clk) disable iff (rst)
        ev_i.retrace_end |=> wake_curt_o);
    a_r3_block_clears: assert property (@(posedge clk) disable iff (rst)
        blk_dht_i && !ev_i.field_start |=> !wake_dht_o);
endmodule

// File: rtl/dsp_wake_ctrl.sv
module dsp_wake_ctrl
    import dsp_wake_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int WORD_W      = 16,
    parameter int BASE_PERIOD = 16,
    parameter int PER_W       = $clog2(2 * BASE_PERIOD + 1),
    parameter int UIDX_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vblank_i,
    input  logic              vsync_i,
    input  logic              hblank_i,
    input  logic              hsync_i,
    input  logic              scanend_i,
    input  logic              mode_wr_i,
    input  logic              mode_invert_i,
    input  logic              mode_speedy_i,
    input  logic              fifo_push_i,
    input  logic              fifo_pop_i,
    input  logic              blk_dvt_i,
    input  logic              blk_dht_i,
    input  logic              blk_dwt_i,
    input  logic              blk_curt_i,
    output logic              wake_dvt_o,
    output logic              wake_dht_o,
    output logic              wake_dwt_o,
    output logic              wake_curt_o,
    output logic              fifo_clr_o,
    output logic              fifo_full_o,
    output logic              fifo_empty_o,
    output logic [WORD_W-1:0] pix_mask_o,
    output logic              half_clk_o,
    output logic              unload_start_o,
    output logic [PER_W-1:0]  unload_period_o,
    output logic              unload_active_o,
    output logic [UIDX_W-1:0] unload_word_o
);
    tflags_t flags;
    tev_t    ev;
    mode_t   pend_q, live_q;
    logic    clr_q, ustart_q, uactive_q, pop_ok;
    logic [PER_W-1:0]  period_q;
    logic [UIDX_W-1:0] uword_q;

    assign flags = '{vblank: vblank_i, vsync: vsync_i, hblank: hblank_i, hsync: hsync_i};

    dsp_edge_det u_edges (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags),
        .ev_o    (ev)
    );

    dsp_fifo_ptrs #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (ev.retrace_begin),
        .push_i   (fifo_push_i),
        .pop_i    (fifo_pop_i),
        .full_o   (fifo_full_o),
        .empty_o  (fifo_empty_o),
        .pop_ok_o (pop_ok)
    );

    dsp_task_wake u_wake (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (ev),
        .scanend_i   (scanend_i),
        .fifo_full_i (fifo_full_o),
        .blk_dvt_i   (blk_dvt_i),
        .blk_dht_i   (blk_dht_i),
        .blk_dwt_i   (blk_dwt_i),
        .blk_curt_i  (blk_curt_i),
        .wake_dvt_o  (wake_dvt_o),
        .wake_dht_o  (wake_dht_o),
        .wake_dwt_o  (wake_dwt_o),
        .wake_curt_o (wake_curt_o)
    );

    // mode bits: stored on write, applied at start of retrace
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            live_q <= '0;
        end else begin
            if (mode_wr_i)         pend_q <= '{invert: mode_invert_i, speedy: mode_speedy_i};
            if (ev.retrace_begin)  live_q <= pend_q;
        end
    end

    // line unload sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q     <= 1'b0;
            ustart_q  <= 1'b0;
            uactive_q <= 1'b0;
            period_q  <= PER_W'(BASE_PERIOD);
            uword_q   <= '0;
        end else begin
            clr_q    <= ev.retrace_begin;
            ustart_q <= ev.line_unload;
            if (ev.line_unload)
                period_q <= PER_W'(unload_bits(live_q.speedy, BASE_PERIOD));
            if (ev.retrace_begin)    uactive_q <= 1'b0;
            else if (ev.line_unload) uactive_q <= 1'b1;
            if (ev.line_unload)               uword_q <= '0;
            else if (uactive_q && pop_ok)     uword_q <= uword_q + UIDX_W'(1);
        end
    end

    assign fifo_clr_o      = clr_q;
    assign pix_mask_o      = {WORD_W{live_q.invert}};
    assign half_clk_o      = live_q.speedy;
    assign unload_start_o  = ustart_q;
    assign unload_period_o = period_q;
    assign unload_active_o = uactive_q;
    assign unload_word_o   = uword_q;

    a_r8_mode_held: assert property (@(posedge clk) disable iff (rst)
        !ev.retrace_begin |=> $stable(pix_mask_o) && $stable(half_clk_o));
    a_r9_unload_restart: assert property (@(posedge clk) disable iff (rst)
        ev.line_unload |=> unload_start_o && unload_word_o == '0);
    a_r7_retrace_stops_unload: assert property (@(posedge clk) disable iff (rst)
        ev.retrace_begin |=> fifo_clr_o && !unload_active_o);
    a_r12_count_only_active: assert property (@(posedge clk) disable iff (rst)
        !unload_active_o && !ev.line_unload |=> $stable(unload_word_o));
endmodule

// File: tb/dsp_wake_ctrl_test.sv
`timescale 1ns/1ps
module dsp_wake_ctrl_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, vblank, vsync, hblank, hsync, scanend;
    logic mode_wr, mode_inv, mode_spd, push, pop;
    logic b_dvt, b_dht, b_dwt, b_curt;
    logic w_dvt, w_dht, w_dwt, w_curt, clr, full, empty, half, ustart, uactive;
    logic [15:0] mask;
    logic [5:0]  period;
    logic [4:0]  uword;

    int tests = 0;
    int fails = 0;

    dsp_wake_ctrl uut (
        .clk(clk), .rst(rst),
        .vblank_i(vblank), .vsync_i(vsync), .hblank_i(hblank), .hsync_i(hsync),
        .scanend_i(scanend), .mode_wr_i(mode_wr), .mode_invert_i(mode_inv),
        .mode_speedy_i(mode_spd), .fifo_push_i(push), .fifo_pop_i(pop),
        .blk_dvt_i(b_dvt), .blk_dht_i(b_dht), .blk_dwt_i(b_dwt), .blk_curt_i(b_curt),
        .wake_dvt_o(w_dvt), .wake_dht_o(w_dht), .wake_dwt_o(w_dwt), .wake_curt_o(w_curt),
        .fifo_clr_o(clr), .fifo_full_o(full), .fifo_empty_o(empty),
        .pix_mask_o(mask), .half_clk_o(half), .unload_start_o(ustart),
        .unload_period_o(period), .unload_active_o(uactive), .unload_word_o(uword)
    );

    // {vb vs hb hs se} {blk dvt dht curt} {exp dvt dht curt clr ustart}
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        13'b00000_000_00000,
        13'b10000_000_00000,
        13'b11000_000_10000,
        13'b11000_100_00000,
        13'b10000_000_00000,
        13'b00000_000_01000,
        13'b00100_010_00000,
        13'b00000_000_00001,
        13'b00010_000_00010,
        13'b00000_000_00100,
        13'b00000_001_00000,
        13'b10000_000_00000,
        13'b00000_000_01000,
        13'b00010_000_01010,
        13'b00000_010_00100,
        13'b00010_000_00110,
        13'b01000_000_00100,
        13'b00000_001_00000
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        {vblank, vsync, hblank, hsync, scanend} = '0;
        {mode_wr, mode_inv, mode_spd, push, pop} = '0;
        {b_dvt, b_dht, b_dwt, b_curt} = '0;
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R11 reset state
        check("R11 wakes", {28'd0, w_dvt, w_dht, w_dwt, w_curt}, 32'd0);
        check("R11 fifo empty", {30'd0, empty, full}, 32'd2);
        check("R11 mode", {15'd0, half, mask}, 32'd0);
        check("R11 period", {26'd0, period}, 32'd16);
        check("R11 unload", {26'd0, uactive, ustart, clr, 3'd0}, 32'd0);

        // table: R1 R2 R3 R7 R9 R10
        for (int i = 0; i < NV; i++) begin
            {vblank, vsync, hblank, hsync, scanend} = VEC[i][12:8];
            {b_dvt, b_dht, b_curt} = VEC[i][7:5];
            step();
            check($sformatf("R1 R2 R3 R7 R9 R10 vector %0d", i),
                  {27'd0, w_dvt, w_dht, w_curt, clr, ustart}, {27'd0, VEC[i][4:0]});
        end

        // directed word-task and FIFO cases
        do_reset();
        step();
        check("R4 idle wake", {31'd0, w_dwt}, 32'd1);
        push = 1'b1;
        for (int i = 0; i < 16; i++) step();
        check("R6 full after 16", {31'd0, full}, 32'd1);
        step();
        check("R4 full stops wake", {31'd0, w_dwt}, 32'd0);
        push = 1'b0; pop = 1'b1;
        step();
        check("R6 push while full ignored", {31'd0, full}, 32'd0);
        pop = 1'b0;
        hsync = 1'b1;
        step();
        check("R7 clear pulse and empty", {30'd0, clr, empty}, 32'd3);
        hsync = 1'b0;
        step();
        pop = 1'b1;
        step();
        pop = 1'b0; push = 1'b1;
        step();
        push = 1'b0;
        check("R6 pop while empty ignored", {31'd0, empty}, 32'd0);

        scanend = 1'b1;
        step();
        check("R5 scanend clears", {31'd0, w_dwt}, 32'd0);
        scanend = 1'b0;
        step();
        check("R4 wake after scanend", {31'd0, w_dwt}, 32'd1);

        b_dwt = 1'b1;
        step();
        b_dwt = 1'b0;
        step();
        step();
        check("R4 word block holds", {31'd0, w_dwt}, 32'd0);
        hsync = 1'b1;
        step();
        step();
        check("R7 retrace releases word block", {31'd0, w_dwt}, 32'd1);

        b_dht = 1'b1;
        step();
        b_dht = 1'b0;
        step();
        check("R4 horizontal block gates word", {31'd0, w_dwt}, 32'd0);
        vblank = 1'b1;
        step();
        vblank = 1'b0;
        step();
        step();
        check("R2 field start releases block", {30'd0, w_dht, w_dwt}, 32'd3);

        // mode and unload
        hsync = 1'b0;
        step();
        mode_wr = 1'b1; mode_inv = 1'b1; mode_spd = 1'b1;
        step();
        mode_wr = 1'b0; mode_inv = 1'b0; mode_spd = 1'b0;
        step();
        check("R8 mode not yet applied", {15'd0, half, mask}, 32'd0);
        hblank = 1'b1;
        step();
        hblank = 1'b0;
        step();
        check("R9 unload 16", {25'd0, ustart, uactive, period}, {25'd0, 2'b11, 6'd16});
        hsync = 1'b1;
        step();
        check("R8 mode applied", {15'd0, half, mask}, {15'd0, 1'b1, 16'hFFFF});
        check("R7 unload stopped", {31'd0, uactive}, 32'd0);
        hsync = 1'b0;
        step();
        hblank = 1'b1;
        step();
        hblank = 1'b0;
        step();
        check("R9 unload 32 half clock", {20'd0, ustart, uactive, uword, period},
              {20'd0, 2'b11, 5'd0, 6'd32});
        push = 1'b1;
        step();
        step();
        push = 1'b0; pop = 1'b1;
        step();
        check("R12 one word", {27'd0, uword}, 32'd1);
        step();
        step();
        pop = 1'b0;
        check("R12 stops at empty", {27'd0, uword}, 32'd2);
        check("R9 start is a pulse", {31'd0, ustart}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule